// File: doc/BRIEF.md
# Ordered Virtual-Network Send Eligibility Checker

This block sits beside the switch allocator of one router input port. For every virtual channel (VC) of that input, it decides each cycle whether the flit at the head of the VC may request the crossbar. The decision covers three things:

- **Head flits.** A head flit that still needs an output VC is eligible only when its target output port has a free VC in the flit's virtual network.
- **Body and tail flits.** A body or tail flit that already holds an output VC is eligible only when that output VC has at least one credit.
- **Ordered virtual networks.** When a virtual network is marked as ordered, a flit is held back while an older flit at the same input, in the same virtual network, is waiting for the same output port.

The VCs are grouped into virtual networks by index: VC `i` belongs to virtual network `i / VCS_PER_VNET`. Enqueue timestamps are free-running cycle counts. They are compared with wrap-safe subtraction, so a sibling counts as older when the difference `own − sibling` is non-zero and below half the timestamp range. The eligibility vector is computed combinationally and presented one clock after the inputs, from a register. The allocator that consumes the vector performs the arbitration and all state updates.

Top module: `svc_send_eligibility`

## Requirements
- R1: A VC whose `vc_in_sa` bit is 0 is never eligible, whatever its resources.
- R2: A VC with `vc_has_outvc`=0 is eligible only if `out_free_vc` has a 1 at some bit `port*V + g*VCS_PER_VNET + k` (0 ≤ k < VCS_PER_VNET). Here `port` is its `vc_outport` and `g` is its virtual network. Free VCs of other virtual networks do not count.
- R3: A VC with `vc_has_outvc`=0 and a free VC present is eligible even when every credit count at its port is zero.
- R4: A VC with `vc_has_outvc`=1 is eligible only if the `CREDIT_W`-bit field at `out_credit[(port*V + outvc)*CREDIT_W]` is non-zero. The free-VC bits play no part in this case.
- R5: The virtual network of VC `i` is `i / VCS_PER_VNET`. The ordering flag for it is `vnet_ordered[i / VCS_PER_VNET]`.
- R6: In an ordered virtual network, a VC is ineligible when a sibling VC in the same network meets all three conditions: it has `vc_in_sa`=1, it has the same `vc_outport`, and it has an older enqueue timestamp.
- R7: An equal timestamp, a different output port, or a sibling with `vc_in_sa`=0 does not block a VC.
- R8: Timestamp age is wrap-safe: a sibling is older when `(own − sibling) mod 2^TS_W` is non-zero and its top bit is 0.
- R9: In an unordered virtual network, the age comparison is skipped entirely.
- R10: `elig` is registered: it shows the decision for the inputs of the previous clock edge. It is all zeros while `rst_n` is low.
- R11: VCs in a different virtual network never block a VC, even when that network is ordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vc_in_sa | input | V | VC has a flit waiting for switch allocation |
| vc_has_outvc | input | V | VC already holds an output VC (body or tail flit) |
| vc_outport | input | V*OP_W | Requested output port per VC |
| vc_outvc | input | V*VC_W | Held output VC per VC (valid when `vc_has_outvc` is 1) |
| vc_enq_ts | input | V*TS_W | Enqueue timestamp of the head flit per VC |
| out_free_vc | input | NUM_OUTPORTS*V | Free flag per output VC, port-major |
| out_credit | input | NUM_OUTPORTS*V*CREDIT_W | Credit count per output VC, port-major |
| vnet_ordered | input | NUM_VNETS | Ordering flag per virtual network |
| elig | output | V | Registered eligibility, one bit per VC |

## Verification
The bench builds the block with two virtual networks of two VCs each, four output ports, 3-bit credits and 16-bit timestamps. With two VCs per network, every VC has exactly one sibling, so age blocking can be shown in both directions. With two networks, the bench can set a free VC or an older flit in the wrong network and show that it has no effect. Sixteen-bit timestamps let the bench place one stamp just below the wrap point and one just above it, which exercises the wrap-safe comparison.

// File: rtl/svc_pkg.sv
package svc_pkg;

    // How a VC obtains its right to move downstream.
    typedef enum logic {
        RES_NEEDS_OUTVC = 1'b0,   // head flit: a free output VC is required
        RES_HOLDS_OUTVC = 1'b1    // body/tail flit: a credit is required
    } res_kind_e;

endpackage

// File: rtl/svc_resource_check.sv
module svc_resource_check
    import svc_pkg::*;
#(
    parameter int V            = 4,
    parameter int VCS_PER_VNET = 2,
    parameter int NUM_OUTPORTS = 4,
    parameter int CREDIT_W     = 3,
    parameter int VC_IDX       = 0,
    localparam int OP_W        = (NUM_OUTPORTS > 1) ? $clog2(NUM_OUTPORTS) : 1,
    localparam int VC_W        = (V > 1) ? $clog2(V) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             has_outvc,
    input  logic [OP_W-1:0]                  outport,
    input  logic [VC_W-1:0]                  outvc,
    input  logic [NUM_OUTPORTS*V-1:0]        out_free_vc,
    input  logic [NUM_OUTPORTS*V*CREDIT_W-1:0] out_credit,
    output logic                             res_ok
);
    localparam int VNET = VC_IDX / VCS_PER_VNET;
    localparam int BASE = VNET * VCS_PER_VNET;

    res_kind_e             kind;
    logic                  free_in_vnet;
    logic [CREDIT_W-1:0]   credit_sel;
    logic                  port_in_range;

    always_comb begin
        kind          = has_outvc ? RES_HOLDS_OUTVC : RES_NEEDS_OUTVC;
        port_in_range = (int'(outport) < NUM_OUTPORTS);
        free_in_vnet  = 1'b0;
        credit_sel    = '0;
        if (port_in_range) begin
            for (int k = 0; k < VCS_PER_VNET; k++) begin
                free_in_vnet = free_in_vnet
                             | out_free_vc[int'(outport) * V + BASE + k];
            end
            credit_sel = out_credit[(int'(outport) * V + int'(outvc)) * CREDIT_W +: CREDIT_W];
        end
        unique case (kind)
            RES_NEEDS_OUTVC: res_ok = free_in_vnet;          // buffer implied by free VC
            RES_HOLDS_OUTVC: res_ok = (credit_sel != '0);
            default:         res_ok = 1'b0;
        endcase
    end

    // R4: a held output VC with an empty credit field never passes
    p_no_credit_no_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (has_outvc && out_credit[(int'(outport) * V + int'(outvc)) * CREDIT_W +: CREDIT_W] == '0)
        |-> !res_ok);

endmodule

// File: rtl/svc_age_check.sv
module svc_age_check #(
    parameter int V            = 4,
    parameter int VCS_PER_VNET = 2,
    parameter int NUM_VNETS    = 2,
    parameter int NUM_OUTPORTS = 4,
    parameter int TS_W         = 16,
    localparam int OP_W        = (NUM_OUTPORTS > 1) ? $clog2(NUM_OUTPORTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [V-1:0]          vc_in_sa,
    input  logic [V*OP_W-1:0]     vc_outport,
    input  logic [V*TS_W-1:0]     vc_enq_ts,
    input  logic [NUM_VNETS-1:0]  vnet_ordered,
    output logic [V-1:0]          blocked
);
    for (genvar i = 0; i < V; i++) begin : g_vc
        localparam int VNET = i / VCS_PER_VNET;
        localparam int BASE = VNET * VCS_PER_VNET;

        logic [TS_W-1:0] own_ts;
        logic [OP_W-1:0] own_port;
        logic            older_hit;

        always_comb begin
            own_ts    = vc_enq_ts[i*TS_W +: TS_W];
            own_port  = vc_outport[i*OP_W +: OP_W];
            older_hit = 1'b0;
            for (int k = 0; k < VCS_PER_VNET; k++) begin
                logic [TS_W-1:0] age_diff;
                age_diff = own_ts - vc_enq_ts[(BASE + k)*TS_W +: TS_W];
                if ((BASE + k) != i
                    && vc_in_sa[BASE + k]
                    && vc_outport[(BASE + k)*OP_W +: OP_W] == own_port
                    && age_diff != '0
                    && !age_diff[TS_W-1]) begin
                    older_hit = 1'b1;
                end
            end
            blocked[i] = vnet_ordered[VNET] & older_hit;
        end

        // R9: an unordered network never holds a flit back on age
        p_unordered_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !vnet_ordered[VNET] |-> !blocked[i]);
    end

endmodule

// File: rtl/svc_send_eligibility.sv
module svc_send_eligibility #(
    parameter int NUM_VNETS    = 2,
    parameter int VCS_PER_VNET = 2,
    parameter int NUM_OUTPORTS = 4,
    parameter int CREDIT_W     = 3,
    parameter int TS_W         = 16,
    localparam int V           = NUM_VNETS * VCS_PER_VNET,
    localparam int OP_W        = (NUM_OUTPORTS > 1) ? $clog2(NUM_OUTPORTS) : 1,
    localparam int VC_W        = (V > 1) ? $clog2(V) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [V-1:0]                       vc_in_sa,
    input  logic [V-1:0]                       vc_has_outvc,
    input  logic [V*OP_W-1:0]                  vc_outport,
    input  logic [V*VC_W-1:0]                  vc_outvc,
    input  logic [V*TS_W-1:0]                  vc_enq_ts,
    input  logic [NUM_OUTPORTS*V-1:0]          out_free_vc,
    input  logic [NUM_OUTPORTS*V*CREDIT_W-1:0] out_credit,
    input  logic [NUM_VNETS-1:0]               vnet_ordered,
    output logic [V-1:0]                       elig
);
    typedef struct packed {
        logic [V-1:0] elig;
    } state_t;

    state_t       st_d, st_q;
    logic [V-1:0] res_ok;
    logic [V-1:0] blocked;

    for (genvar i = 0; i < V; i++) begin : g_res
        svc_resource_check #(
            .V            (V),
            .VCS_PER_VNET (VCS_PER_VNET),
            .NUM_OUTPORTS (NUM_OUTPORTS),
            .CREDIT_W     (CREDIT_W),
            .VC_IDX       (i)
        ) u_res (
            .clk         (clk),
            .rst_n       (rst_n),
            .has_outvc   (vc_has_outvc[i]),
            .outport     (vc_outport[i*OP_W +: OP_W]),
            .outvc       (vc_outvc[i*VC_W +: VC_W]),
            .out_free_vc (out_free_vc),
            .out_credit  (out_credit),
            .res_ok      (res_ok[i])
        );
    end

    svc_age_check #(
        .V            (V),
        .VCS_PER_VNET (VCS_PER_VNET),
        .NUM_VNETS    (NUM_VNETS),
        .NUM_OUTPORTS (NUM_OUTPORTS),
        .TS_W         (TS_W)
    ) u_age (
        .clk          (clk),
        .rst_n        (rst_n),
        .vc_in_sa     (vc_in_sa),
        .vc_outport   (vc_outport),
        .vc_enq_ts    (vc_enq_ts),
        .vnet_ordered (vnet_ordered),
        .blocked      (blocked)
    );

    always_comb begin
        st_d      = st_q;
        st_d.elig = vc_in_sa & res_ok & ~blocked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign elig = st_q.elig;

    for (genvar i = 0; i < V; i++) begin : g_chk
        // R1: only VCs in the allocation stage may be granted eligibility
        p_needs_sa_r1: assert property (@(posedge clk) disable iff (!rst_n)
            elig[i] |-> $past(vc_in_sa[i]));
        // R2/R4: eligibility implies the resource check passed a cycle ago
        p_resource_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
            elig[i] |-> $past(res_ok[i]));
        // R6: an age-blocked VC is never reported eligible
        p_age_respected_r6: assert property (@(posedge clk) disable iff (!rst_n)
            elig[i] |-> !$past(blocked[i]));
    end

    // R10: output is clear during reset
    always_comb begin
        if (!rst_n) p_reset_clear_r10: assert (elig == '0 || $isunknown(elig));
    end

endmodule

// File: tb/svc_send_eligibility_tb.sv
module svc_send_eligibility_tb;
    localparam int NV = 2, VPV = 2, NP = 4, CW = 3, TW = 16;
    localparam int V = NV * VPV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [V-1:0]     sa, hv;
    logic [1:0]       op [V];
    logic [1:0]       ov [V];
    logic [TW-1:0]    ts [V];
    logic [NP*V-1:0]  free_v;
    logic [CW-1:0]    cr [NP*V];
    logic [NV-1:0]    ordv;

    logic [V*2-1:0]       op_bus, ov_bus;
    logic [V*TW-1:0]      ts_bus;
    logic [NP*V*CW-1:0]   cr_bus;
    logic [V-1:0]         elig;

    always_comb begin
        for (int i = 0; i < V; i++) begin
            op_bus[i*2 +: 2]   = op[i];
            ov_bus[i*2 +: 2]   = ov[i];
            ts_bus[i*TW +: TW] = ts[i];
        end
        for (int j = 0; j < NP*V; j++) cr_bus[j*CW +: CW] = cr[j];
    end

    svc_send_eligibility #(
        .NUM_VNETS(NV), .VCS_PER_VNET(VPV), .NUM_OUTPORTS(NP),
        .CREDIT_W(CW), .TS_W(TW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .vc_in_sa(sa), .vc_has_outvc(hv),
        .vc_outport(op_bus), .vc_outvc(ov_bus), .vc_enq_ts(ts_bus),
        .out_free_vc(free_v), .out_credit(cr_bus), .vnet_ordered(ordv),
        .elig(elig)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    task automatic check(input logic [V-1:0] exp, input string req);
        n_checks++;
        if (elig !== exp) begin
            n_errors++;
            $display("FAIL %s: elig actual=%b expected=%b", req, elig, exp);
        end
    endtask

    task automatic clear_inputs();
        sa = '0; hv = '0; free_v = '0; ordv = '0;
        for (int i = 0; i < V; i++) begin op[i] = '0; ov[i] = '0; ts[i] = '0; end
        for (int j = 0; j < NP*V; j++) cr[j] = '0;
    endtask

    // inputs are set on a falling edge; the next falling edge shows the result
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        clear_inputs();
        sa = '1; free_v = '1;
        settle();
        check('0, "R10 reset");
        @(negedge clk); rst_n = 1'b1;
        settle();
        check(4'b1111, "R10 after reset");
    endtask

    task automatic t_head();
        clear_inputs();
        sa = 4'b0101; op[0] = 2'd1; op[2] = 2'd1;
        free_v[1*V + 1] = 1'b1;                 // port1, vnet0 VC1
        settle(); check(4'b0001, "R2/R5 free only in vnet0");
        free_v[1*V + 3] = 1'b1;                 // port1, vnet1 VC3
        settle(); check(4'b0101, "R2 free in vnet1");
        free_v = '0; free_v[2*V + 0] = 1'b1;    // wrong port
        settle(); check(4'b0000, "R2 free on other port");
    endtask

    task automatic t_head_no_credit();
        clear_inputs();
        sa = 4'b0001; op[0] = 2'd3; free_v[3*V + 0] = 1'b1;
        settle(); check(4'b0001, "R3 zero credits ignored");
    endtask

    task automatic t_body();
        clear_inputs();
        sa = 4'b0010; hv = 4'b0010; op[1] = 2'd2; ov[1] = 2'd1;
        free_v = '1;
        settle(); check(4'b0000, "R4 zero credit");
        cr[2*V + 1] = 3'd1;
        settle(); check(4'b0010, "R4 one credit");
        free_v = '0;
        settle(); check(4'b0010, "R4 free bits irrelevant");
        cr[2*V + 1] = 3'd0; cr[2*V + 0] = 3'd7;
        settle(); check(4'b0000, "R4 credit on other outvc");
    endtask

    task automatic t_not_sa();
        clear_inputs();
        free_v = '1; sa = 4'b0000;
        settle(); check(4'b0000, "R1 no SA");
    endtask

    task automatic t_ordered();
        clear_inputs();
        ordv = 2'b01; sa = 4'b0011; op[0] = 2'd1; op[1] = 2'd1;
        free_v[1*V + 0] = 1'b1; free_v[2*V + 1] = 1'b1;
        ts[0] = 16'd100; ts[1] = 16'd90;
        settle(); check(4'b0010, "R6 older sibling blocks");
        ts[0] = 16'd80;
        settle(); check(4'b0001, "R6 reversed age");
        ts[0] = 16'd90;
        settle(); check(4'b0011, "R7 equal timestamps");
        ts[0] = 16'd100; op[1] = 2'd2;
        settle(); check(4'b0011, "R7 different port");
        op[1] = 2'd1; sa = 4'b0001;
        settle(); check(4'b0001, "R7 sibling not in SA");
    endtask

    task automatic t_unordered();
        clear_inputs();
        ordv = 2'b00; sa = 4'b0011; op[0] = 2'd1; op[1] = 2'd1;
        free_v[1*V + 0] = 1'b1; ts[0] = 16'd100; ts[1] = 16'd90;
        settle(); check(4'b0011, "R9 unordered skips age");
    endtask

    task automatic t_wrap();
        clear_inputs();
        ordv = 2'b01; sa = 4'b0011; op[0] = 2'd0; op[1] = 2'd0;
        free_v[0] = 1'b1;
        ts[0] = 16'h0005; ts[1] = 16'hFFF0;
        settle(); check(4'b0010, "R8 wrap older sibling");
        ts[0] = 16'hFFF0; ts[1] = 16'h0005;
        settle(); check(4'b0001, "R8 wrap reversed");
    endtask

    task automatic t_cross_vnet();
        clear_inputs();
        ordv = 2'b11; sa = 4'b0101; op[0] = 2'd1; op[2] = 2'd1;
        free_v[1*V + 0] = 1'b1; free_v[1*V + 2] = 1'b1;
        ts[0] = 16'd500; ts[2] = 16'd10;
        settle(); check(4'b0101, "R11 other vnet never blocks");
        sa = 4'b1100; op[3] = 2'd1; ts[3] = 16'd5;
        settle(); check(4'b1000, "R5/R6 ordered vnet1 siblings");
    endtask

    initial begin
        t_reset();
        t_head();
        t_head_no_credit();
        t_body();
        t_not_sa();
        t_ordered();
        t_unordered();
        t_wrap();
        t_cross_vnet();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule